// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a physical address by comparing it against a programmable set of block-translation entries. Each entry is a pair of 32-bit words, an upper word and a lower word. Instruction fetches are looked up in one array and data accesses in a second array. A software write port loads either word of any entry. Each request carries the effective address, a fetch/data flag, a write flag and a privilege flag. One cycle later the unit answers with a status (hit, miss or protection fault), the physical address and the granted permissions.

A mode input picks how the entry words are decoded. In the classic layout, the upper word carries the block-length field and one valid flag per privilege level, and the lower word carries the protection code. In the legacy layout, the block length and a single valid flag sit in the lower word, and the upper word carries the protection code and a protection key for each privilege level. A second input sets how many entries are scanned, from zero up to the storage depth. An unmatched request is reported as a miss, so that a later translation stage can take over.

Top module: `blk_xlate_unit`

## Requirements
- R1: After reset every entry word in both arrays is zero, so no entry is valid. Before the first request, rsp_valid, rsp_status, rsp_pa and rsp_perm are all zero.
- R2: A request sampled with req_valid high at a clock edge is answered with rsp_valid high right after that edge. A cycle without a request leaves rsp_valid low after the next edge.
- R3: Classic layout (cfg_legacy=0):
  - The block mask bits [27:17] are the upper word's bits [12:2].
  - An entry matches when EA[31:28] equals upper[31:28] and EA[27:17] AND NOT mask equals upper[27:17].
  - The entry is valid for supervisor access (req_user=0) when upper bit 1 is set, and for user access when upper bit 0 is set.
- R4: Classic protection code = lower[1:0]. Code 0 grants nothing. Any other code grants read and execute, and code 2 also grants write. rsp_perm is bit0 read, bit1 write, bit2 execute.
- R5: Legacy layout (cfg_legacy=1): the block mask bits [22:17] are lower[5:0], and mask bits [27:23] are zero. The entry is valid, for either privilege, only when lower bit 6 is set.
- R6: Legacy permissions use code = upper[1:0] and key = upper[3] for supervisor or upper[2] for user.
  - Key 0: codes 0..2 give read/write/execute, and code 3 gives read/execute.
  - Key 1: code 0 gives nothing, code 2 gives read/write/execute, and codes 1 and 3 give read/execute.
- R7: On a hit or a fault, rsp_pa = {lower[31:28], (EA[27:17] AND mask) OR lower[27:17], EA[16:0]}.
- R8: Only entries with index below cfg_count take part in the lookup, however many there are. cfg_count = 0 always gives a miss.
- R9: req_fetch=1 looks up the instruction array and req_fetch=0 the data array. A write with wr_side=1 loads the instruction array and wr_side=0 the data array.
- R10: Of the matching entries that are valid for the request's privilege, the lowest index is used. Matching entries that are not valid are skipped.
- R11: rsp_status is 0 for a miss, 1 for a hit and 2 for a protection fault. A fault is reported when the chosen entry lacks the needed right: execute for a fetch, write for a data write, read for a data read. A miss returns rsp_pa and rsp_perm as zero.
- R12: A write stores wr_data into the upper word (wr_upper=1) or the lower word (wr_upper=0) of entry wr_idx and leaves the other word unchanged. Lookups in later cycles see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_legacy | input | 1 | 0 selects the classic entry layout, 1 the legacy layout |
| cfg_count | input | CNT_W | Number of entries scanned, 0..NUM_ENTRIES |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 1 writes the instruction array, 0 the data array |
| wr_idx | input | IDX_W | Entry index written |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Word written |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| req_write | input | 1 | Data write when set, ignored for fetches |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 miss, 1 hit, 2 protection fault |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights: bit0 read, bit1 write, bit2 execute |

## Verification
The assertions check several properties on every cycle:
- the one-cycle request-to-response timing;
- that a miss carries zero address and rights;
- that the page offset always passes through;
- that a zero entry count can only miss;
- that granted write implies granted read;
- that every entry write lands in the chosen word.

Only the directed scenarios can show the following:
- the decoding of both layouts;
- the mask arithmetic in the physical address;
- the privilege-dependent valid flags and keys;
- the choice between the instruction and data arrays;
- that entries above index four are reached;
- that the lowest valid index wins;
- that the boundary of the entry count is honoured.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;

  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_HIT   = 2'd1,
    ST_FAULT = 2'd2
  } xl_status_e;

  // rights vector: bit0 read, bit1 write, bit2 execute
  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
  } xl_perm_t;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } xl_pair_t;

  localparam xl_perm_t PERM_NONE = 3'b000;
  localparam xl_perm_t PERM_RX   = 3'b101;
  localparam xl_perm_t PERM_RWX  = 3'b111;

  function automatic xl_perm_t classic_rights(input logic [1:0] code);
    case (code)
      2'd0:    return PERM_NONE;
      2'd2:    return PERM_RWX;
      default: return PERM_RX;
    endcase
  endfunction

  function automatic xl_perm_t legacy_rights(input logic key, input logic [1:0] code);
    if (!key) begin
      return (code == 2'd3) ? PERM_RX : PERM_RWX;
    end
    case (code)
      2'd0:    return PERM_NONE;
      2'd2:    return PERM_RWX;
      default: return PERM_RX;
    endcase
  endfunction

endpackage

// File: rtl/xl_pair_bank.sv
module xl_pair_bank
  import blk_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            wr_upper,
  input  logic [31:0]                     wr_data,
  output xl_pair_t [NUM_ENTRIES-1:0]      pairs
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        pairs[e] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        if (wr_upper) pairs[e].hi <= wr_data;
        else          pairs[e].lo <= wr_data;
      end
    end
  end

  // R12: the addressed word holds the written data one cycle later
  assert_written_word_R12: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (($past(wr_upper) ? pairs[$past(wr_idx)].hi : pairs[$past(wr_idx)].lo)
               == $past(wr_data)));

endmodule

// File: rtl/xl_entry_decode.sv
module xl_entry_decode
  import blk_xlate_pkg::*;
(
  input  xl_pair_t    pair,
  input  logic        legacy,
  input  logic        user,
  input  logic [31:17] ea_hi,
  output logic        match,
  output logic        valid,
  output xl_perm_t    perm,
  output logic [14:0] pa_hi
);

  logic [10:0] mask;
  logic        unused_bits;

  assign unused_bits = ^{pair.hi[16:13], pair.lo[16:7]};

  always_comb begin
    if (legacy) begin
      mask  = {5'b0, pair.lo[5:0]};
      valid = pair.lo[6];
      perm  = legacy_rights(user ? pair.hi[2] : pair.hi[3], pair.hi[1:0]);
    end else begin
      mask  = pair.hi[12:2];
      valid = user ? pair.hi[0] : pair.hi[1];
      perm  = classic_rights(pair.lo[1:0]);
    end
  end

  assign match = (ea_hi[31:28] == pair.hi[31:28]) &&
                 ((ea_hi[27:17] & ~mask) == pair.hi[27:17]);
  assign pa_hi = {pair.lo[31:28], (ea_hi[27:17] & mask) | pair.lo[27:17]};

endmodule

// File: rtl/xl_prio_pick.sv
module xl_prio_pick
  import blk_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic [NUM_ENTRIES-1:0]         cand,
  input  logic [NUM_ENTRIES-1:0][14:0]   pa_hi_in,
  input  xl_perm_t [NUM_ENTRIES-1:0]     perm_in,
  output logic                           found,
  output logic [14:0]                    pa_hi,
  output xl_perm_t                       perm
);

  // scan from the top so the lowest candidate index is the last to write
  always_comb begin
    found = 1'b0;
    pa_hi = '0;
    perm  = PERM_NONE;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        pa_hi = pa_hi_in[i];
        perm  = perm_in[i];
      end
    end
  end

endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit
  import blk_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_legacy,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             wr_en,
  input  logic             wr_side,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_upper,
  input  logic [31:0]      wr_data,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic             req_fetch,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [31:0]      rsp_pa,
  output logic [2:0]       rsp_perm
);

  localparam int NUM_SIDES = 2;  // index 0 data, index 1 instruction

  xl_pair_t [NUM_ENTRIES-1:0] side_pairs [NUM_SIDES];

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    xl_pair_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en && (wr_side == 1'(s))),
      .wr_idx   (wr_idx),
      .wr_upper (wr_upper),
      .wr_data  (wr_data),
      .pairs    (side_pairs[s])
    );
  end

  // one set of comparators, shared by selecting the array first
  xl_pair_t [NUM_ENTRIES-1:0]       act_pairs;
  logic     [NUM_ENTRIES-1:0]       ent_match, ent_valid, ent_in_rng, cand;
  xl_perm_t [NUM_ENTRIES-1:0]       ent_perm;
  logic     [NUM_ENTRIES-1:0][14:0] ent_pa_hi;

  assign act_pairs = req_fetch ? side_pairs[1] : side_pairs[0];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_dec
    xl_entry_decode u_dec (
      .pair   (act_pairs[i]),
      .legacy (cfg_legacy),
      .user   (req_user),
      .ea_hi  (req_ea[31:17]),
      .match  (ent_match[i]),
      .valid  (ent_valid[i]),
      .perm   (ent_perm[i]),
      .pa_hi  (ent_pa_hi[i])
    );
    assign ent_in_rng[i] = (CNT_W'(i) < cfg_count);
    assign cand[i]       = ent_match[i] && ent_valid[i] && ent_in_rng[i];
  end

  logic        pick_found;
  logic [14:0] pick_pa_hi;
  xl_perm_t    pick_perm;

  xl_prio_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .cand     (cand),
    .pa_hi_in (ent_pa_hi),
    .perm_in  (ent_perm),
    .found    (pick_found),
    .pa_hi    (pick_pa_hi),
    .perm     (pick_perm)
  );

  logic       denied;
  xl_status_e nxt_status;

  assign denied = req_fetch ? !pick_perm.ex :
                  (req_write ? !pick_perm.wr : !pick_perm.rd);

  always_comb begin
    if (!pick_found) nxt_status = ST_MISS;
    else if (denied) nxt_status = ST_FAULT;
    else             nxt_status = ST_HIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_pa     <= '0;
      rsp_perm   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= nxt_status;
        rsp_pa     <= pick_found ? {pick_pa_hi, req_ea[16:0]} : 32'h0;
        rsp_perm   <= pick_found ? pick_perm : PERM_NONE;
      end
    end
  end

  // R2: response follows request by exactly one cycle
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R8: nothing is scanned with a zero entry count
  assert_zero_count_miss_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (cfg_count == '0)) |=> (rsp_status == ST_MISS));
  // R7: the page offset passes through on a hit or fault
  assert_offset_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pick_found) |=> (rsp_pa[11:0] == $past(req_ea[11:0])));
  // R11: a miss carries no address and no rights, the status code is legal
  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status == ST_MISS)) |-> ((rsp_pa == '0) && (rsp_perm == '0)));
  assert_status_legal_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_status != 2'd3);
  assert_full_rights_no_fault_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_status == ST_FAULT) |-> (rsp_perm != 3'b111));
  // R6 / R4: write right is never granted without read right
  assert_write_needs_read_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_perm[1] |-> rsp_perm[0]);

endmodule

// File: tb/blk_xlate_unit_test.sv
`timescale 1ns/1ps
module blk_xlate_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_legacy = 1'b0;
  logic [3:0]  cfg_count = 4'd8;
  logic        wr_en = 1'b0, wr_side = 1'b0, wr_upper = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_perm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blk_xlate_unit uut (
    .clk(clk), .rst(rst), .cfg_legacy(cfg_legacy), .cfg_count(cfg_count),
    .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx), .wr_upper(wr_upper),
    .wr_data(wr_data), .req_valid(req_valid), .req_ea(req_ea),
    .req_fetch(req_fetch), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
    .rsp_perm(rsp_perm)
  );

  localparam logic [1:0] MISS = 2'd0, HIT = 2'd1, FLT = 2'd2;

  task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual status/pa/perm %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_word(input bit side, input int idx, input bit upper, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_idx = 3'(idx); wr_upper = upper; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_entry(input bit side, input int idx, input logic [31:0] up, input logic [31:0] lo);
    put_word(side, idx, 1'b1, up);
    put_word(side, idx, 1'b0, lo);
  endtask

  // drive at a falling edge, response is registered at the next rising edge
  task automatic lookup(input string tag, input logic [31:0] ea, input bit fetch,
                        input bit wr, input bit user, input logic [1:0] st,
                        input logic [31:0] pa, input logic [2:0] perm);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_fetch = fetch; req_write = wr; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 valid"}, {38'b0, rsp_valid}, {38'b0, 1'b1});
    check(tag, {1'b0, rsp_status, rsp_pa, rsp_perm}, {1'b0, st, pa, perm});
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {rsp_valid, rsp_status, rsp_pa, rsp_perm}, 39'b0);
    lookup("R1 zero entry invalid", 32'h0000_1000, 1'b0, 1'b0, 1'b0, MISS, 32'h0, 3'b000);
    lookup("R1 zero instr entry invalid", 32'h0000_1000, 1'b1, 1'b0, 1'b1, MISS, 32'h0, 3'b000);
    @(negedge clk);
    check("R2 idle response", {38'b0, rsp_valid}, 39'b0);
  endtask

  task automatic t_classic;
    cfg_legacy = 1'b0; cfg_count = 4'd8;
    put_entry(1'b0, 0, 32'h8000_0007, 32'h1000_0002);
    lookup("R3 R7 classic masked hit", 32'h8002_3ABC, 1'b0, 1'b0, 1'b0, HIT, 32'h1002_3ABC, 3'b111);
    lookup("R3 classic user valid", 32'h8002_3ABC, 1'b0, 1'b1, 1'b1, HIT, 32'h1002_3ABC, 3'b111);
    lookup("R3 unmasked bit mismatch", 32'h8004_0000, 1'b0, 1'b0, 1'b0, MISS, 32'h0, 3'b000);
    put_entry(1'b0, 1, 32'h9000_0002, 32'h2000_0001);
    lookup("R4 classic code1 read", 32'h9000_0100, 1'b0, 1'b0, 1'b0, HIT, 32'h2000_0100, 3'b101);
    lookup("R3 supervisor-only entry for user", 32'h9000_0100, 1'b0, 1'b0, 1'b1, MISS, 32'h0, 3'b000);
    lookup("R11 code1 write fault", 32'h9000_0100, 1'b0, 1'b1, 1'b0, FLT, 32'h2000_0100, 3'b101);
    put_entry(1'b0, 2, 32'hA000_0001, 32'h3000_0000);
    lookup("R4 classic code0 no rights", 32'hA000_0010, 1'b0, 1'b0, 1'b1, FLT, 32'h3000_0010, 3'b000);
    put_word(1'b0, 2, 1'b0, 32'h3000_0003);
    lookup("R4 classic code3 write fault", 32'hA000_0010, 1'b0, 1'b1, 1'b1, FLT, 32'h3000_0010, 3'b101);
  endtask

  task automatic t_legacy;
    cfg_legacy = 1'b1;
    put_entry(1'b0, 3, 32'hB000_0000, 32'h4000_0043);
    lookup("R5 R6 legacy key0 code0 write", 32'hB006_1234, 1'b0, 1'b1, 1'b0, HIT, 32'h4006_1234, 3'b111);
    put_word(1'b0, 3, 1'b1, 32'hB000_0003);
    lookup("R6 legacy key0 code3 write fault", 32'hB006_1234, 1'b0, 1'b1, 1'b0, FLT, 32'h4006_1234, 3'b101);
    lookup("R6 legacy key0 code3 read", 32'hB006_1234, 1'b0, 1'b0, 1'b0, HIT, 32'h4006_1234, 3'b101);
    put_word(1'b0, 3, 1'b1, 32'hB000_0008);
    lookup("R6 supervisor key1 code0", 32'hB006_1234, 1'b0, 1'b0, 1'b0, FLT, 32'h4006_1234, 3'b000);
    lookup("R6 user key0 code0", 32'hB006_1234, 1'b0, 1'b1, 1'b1, HIT, 32'h4006_1234, 3'b111);
    put_word(1'b0, 3, 1'b1, 32'hB000_0009);
    lookup("R6 key1 code1 write fault", 32'hB006_1234, 1'b0, 1'b1, 1'b0, FLT, 32'h4006_1234, 3'b101);
    put_word(1'b0, 3, 1'b1, 32'hB000_000A);
    lookup("R6 key1 code2 write", 32'hB006_1234, 1'b0, 1'b1, 1'b0, HIT, 32'h4006_1234, 3'b111);
    put_word(1'b0, 3, 1'b0, 32'h4000_0003);
    lookup("R5 legacy valid bit clear", 32'hB006_1234, 1'b0, 1'b0, 1'b0, MISS, 32'h0, 3'b000);
    cfg_legacy = 1'b0;
  endtask

  task automatic t_count;
    put_entry(1'b0, 6, 32'hC000_0003, 32'h5000_0002);
    cfg_count = 4'd8;
    lookup("R8 entry six reached", 32'hC000_0040, 1'b0, 1'b0, 1'b0, HIT, 32'h5000_0040, 3'b111);
    cfg_count = 4'd6;
    lookup("R8 entry six above count", 32'hC000_0040, 1'b0, 1'b0, 1'b0, MISS, 32'h0, 3'b000);
    cfg_count = 4'd0;
    lookup("R8 zero count", 32'h8002_3ABC, 1'b0, 1'b0, 1'b0, MISS, 32'h0, 3'b000);
    cfg_count = 4'd8;
  endtask

  task automatic t_priority;
    put_entry(1'b0, 4, 32'hD000_0002, 32'h6000_0002);
    put_entry(1'b0, 5, 32'hD000_0003, 32'h7000_0002);
    lookup("R10 lowest index wins", 32'hD000_0000, 1'b0, 1'b0, 1'b0, HIT, 32'h6000_0000, 3'b111);
    lookup("R10 invalid match skipped", 32'hD000_0000, 1'b0, 1'b0, 1'b1, HIT, 32'h7000_0000, 3'b111);
  endtask

  task automatic t_sides;
    put_entry(1'b1, 0, 32'h8000_0003, 32'hE000_0001);
    lookup("R9 fetch uses instr array", 32'h8000_0100, 1'b1, 1'b0, 1'b0, HIT, 32'hE000_0100, 3'b101);
    lookup("R9 data uses data array", 32'h8000_0100, 1'b0, 1'b0, 1'b0, HIT, 32'h1000_0100, 3'b111);
    lookup("R9 data-only region fetch", 32'h9000_0100, 1'b1, 1'b0, 1'b0, MISS, 32'h0, 3'b000);
    put_entry(1'b1, 1, 32'hF000_0003, 32'hF000_0000);
    lookup("R11 fetch without execute", 32'hF000_0004, 1'b1, 1'b0, 1'b0, FLT, 32'hF000_0004, 3'b000);
  endtask

  task automatic t_write_port;
    put_entry(1'b0, 7, 32'h7000_0003, 32'h0000_0002);
    lookup("R12 new entry visible", 32'h7000_0000, 1'b0, 1'b0, 1'b0, HIT, 32'h0000_0000, 3'b111);
    put_word(1'b0, 7, 1'b0, 32'h0100_0002);
    lookup("R12 lower-only rewrite", 32'h7000_0000, 1'b0, 1'b0, 1'b0, HIT, 32'h0100_0000, 3'b111);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_classic();
    t_legacy();
    t_count();
    t_priority();
    t_sides();
    t_write_port();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule